// File: doc/BRIEF.md
# Lookahead Two's-Complement Adder

This block is a purely combinational adder for two operands in two's-complement form, with a carry input and a carry output. It is built as a lookahead adder. It does not use a chain of full adders that each wait on their neighbour. Each bit position is first sorted by its own two operand bits: it creates a carry, passes one along, or absorbs one. A parallel-prefix tree of two-input combine cells then merges these per-bit terms into group terms. The tree is logarithmic in the operand width, so every carry is ready after about log2(WIDTH) cell delays.

The carry input enters at bit 0 and works as an add-one control. A controller can form the negative of a value by feeding in its bitwise complement and raising the carry input. The block also raises a signed-overflow flag. It does this only when the two operands share a sign and the result's sign does not match it.

Top module: `lookahead_adder`

## Requirements
- R1: When both operand bits at a position are 1, the carry out of that position is 1 whatever carry reaches it; with a=b=0x0001 and cin=0 the sum is 0x0002.
- R2: When exactly one operand bit at a position is 1, the carry out of that position equals the carry into it; 0x7FFF plus 0x0000 with cin=1 gives 0x8000.
- R3: When both operand bits at a position are 0, no carry leaves that position; 0xFF00 plus 0x00FF with cin=0 gives 0xFFFF and cout=0.
- R4: sum equals (a + b + cin) modulo 2^WIDTH for every input combination.
- R5: cout equals bit WIDTH of the unbounded total a + b + cin.
- R6: Feeding the bitwise complement of x on a, zero on b and cin=1 yields the two's-complement negation of x.
- R7: ovf is 1 exactly when a and b have equal sign bits (bit WIDTH-1) and sum's sign bit differs from them.
- R8: With operands of opposite sign, ovf stays 0 even when cout is 1; 0xFFFF plus 0x0001 gives sum 0x0000, cout=1, ovf=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, two's complement |
| b | input | WIDTH | Second operand, two's complement |
| cin | input | 1 | Carry into bit 0, used as the add-one control |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the sign position |
| ovf | output | 1 | Signed overflow flag |

## Verification
Two outcomes can land on the same input vector: a carry out of the sign bit, and a signed-overflow flag. They must be told apart, because cout without ovf is legal for mixed-sign operands. Vectors like 0xFFFF+0x0001 give a carry with no overflow. Vectors like 0x8000+0x8000 give both, and 0x7FFF+0x0001 gives overflow with no carry. The exhaustive pass over an 8-bit instance covers every pairing of these two outcomes. The scoreboard checks cout and ovf separately against a model built from the sign-comparison rule.

// File: rtl/la_pkg.sv
package la_pkg;

  typedef enum logic [1:0] {
    BIT_KILL = 2'd0,
    BIT_PROP = 2'd1,
    BIT_GEN  = 2'd2
  } bit_class_e;

  // Classify one position by its generate/propagate pair.
  function automatic bit_class_e classifyBit(input logic genBit, input logic propBit);
    if (genBit)       return BIT_GEN;
    else if (propBit) return BIT_PROP;
    else              return BIT_KILL;
  endfunction

  // Combine a high group (gHi,pHi) with the lower group (gLo,pLo).
  function automatic logic [1:0] combineGp(input logic gHi, input logic pHi,
                                           input logic gLo, input logic pLo);
    return {gHi | (pHi & gLo), pHi & pLo};
  endfunction

endpackage

// File: rtl/la_gp_stage.sv
module la_gp_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] genBits,
  output logic [WIDTH-1:0] propBits
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign genBits[i]  = opA[i] & opB[i];
    assign propBits[i] = opA[i] ^ opB[i];
  end

endmodule

// File: rtl/la_prefix_tree.sv
module la_prefix_tree
  import la_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] genBits,
  input  logic [WIDTH-1:0] propBits,
  input  logic             carryIn,
  output logic [WIDTH:0]   carries
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  // grpG/grpP[l][i] cover positions max(0,i-2^l+1) .. i
  logic [LEVELS:0][WIDTH-1:0] grpG;
  logic [LEVELS:0][WIDTH-1:0] grpP;

  assign grpG[0] = genBits;
  assign grpP[0] = propBits;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int SPAN = 1 << l;
    for (genvar i = 0; i < WIDTH; i++) begin : g_node
      if (i >= SPAN) begin : g_merge
        logic [1:0] merged;
        assign merged = combineGp(grpG[l][i], grpP[l][i],
                                  grpG[l][i-SPAN], grpP[l][i-SPAN]);
        assign grpG[l+1][i] = merged[1];
        assign grpP[l+1][i] = merged[0];
      end else begin : g_pass
        assign grpG[l+1][i] = grpG[l][i];
        assign grpP[l+1][i] = grpP[l][i];
      end
    end
  end

  assign carries[0] = carryIn;
  for (genvar i = 0; i < WIDTH; i++) begin : g_carry
    assign carries[i+1] = grpG[LEVELS][i] | (grpP[LEVELS][i] & carryIn);
  end

  // Local checks on every position, against the per-bit classification.
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      // R1
      gen_carry_chk: assert final (classifyBit(genBits[i], propBits[i]) != BIT_GEN
                                   || carries[i+1])
        else $error("generating position %0d lost its carry", i);
      // R2
      prop_carry_chk: assert final (classifyBit(genBits[i], propBits[i]) != BIT_PROP
                                    || carries[i+1] == carries[i])
        else $error("propagating position %0d altered its carry", i);
      // R3
      kill_carry_chk: assert final (classifyBit(genBits[i], propBits[i]) != BIT_KILL
                                    || !carries[i+1])
        else $error("killing position %0d emitted a carry", i);
    end
  end

endmodule

// File: rtl/la_sum_stage.sv
module la_sum_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] propBits,
  input  logic [WIDTH:0]   carries,
  input  logic             signA,
  input  logic             signB,
  output logic [WIDTH-1:0] sumBits,
  output logic             carryOut,
  output logic             sgnOvf
);

  localparam int MSB = WIDTH - 1;

  assign sumBits  = propBits ^ carries[WIDTH-1:0];
  assign carryOut = carries[WIDTH];
  assign sgnOvf   = (signA == signB) && (sumBits[MSB] != signA);

  always_comb begin
    // R8
    mixed_sign_chk: assert final (signA == signB || !sgnOvf)
      else $error("overflow raised for operands of opposite sign");
    // R7
    sign_flip_chk: assert final (!sgnOvf || (carries[WIDTH] != carries[MSB]))
      else $error("overflow raised without a sign-position carry mismatch");
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  logic [WIDTH-1:0] genBits;
  logic [WIDTH-1:0] propBits;
  logic [WIDTH:0]   carries;

  la_gp_stage #(.WIDTH(WIDTH)) u_gp (
    .opA(a), .opB(b), .genBits(genBits), .propBits(propBits)
  );

  la_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .genBits(genBits), .propBits(propBits), .carryIn(cin), .carries(carries)
  );

  la_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .propBits(propBits), .carries(carries),
    .signA(a[WIDTH-1]), .signB(b[WIDTH-1]),
    .sumBits(sum), .carryOut(cout), .sgnOvf(ovf)
  );

  always_comb begin
    // R6
    negate_chk: assert final (!(cin && b == '0 && a == '1) || sum == '0)
      else $error("complement of zero plus one did not wrap to zero");
  end

endmodule

// File: tb/lookahead_adder_tb.sv
module lookahead_adder_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] a16, b16, sum16;
  logic        cin16, cout16, ovf16;
  logic [7:0]  a8, b8, sum8;
  logic        cin8, cout8, ovf8;

  lookahead_adder #(.WIDTH(16)) u_dut (
    .a(a16), .b(b16), .cin(cin16), .sum(sum16), .cout(cout16), .ovf(ovf16)
  );
  lookahead_adder #(.WIDTH(8)) u_dut8 (
    .a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8), .ovf(ovf8)
  );

  typedef struct {
    bit          wide;
    logic [15:0] expSum;
    logic        expCout;
    logic        expOvf;
    string       tag;
  } exp_item_t;

  exp_item_t scoreQ[$];
  int applied = 0;
  int miscompares = 0;
  bit finished = 0;

  function automatic exp_item_t model16(input logic [15:0] x, input logic [15:0] y,
                                        input logic c, input string tag);
    exp_item_t it;
    logic [16:0] tot;
    tot = {1'b0, x} + {1'b0, y} + {16'd0, c};
    it.wide = 1'b1; it.expSum = tot[15:0]; it.expCout = tot[16];
    it.expOvf = (x[15] == y[15]) && (tot[15] != x[15]);
    it.tag = tag;
    return it;
  endfunction

  function automatic exp_item_t model8(input logic [7:0] x, input logic [7:0] y,
                                       input logic c, input string tag);
    exp_item_t it;
    logic [8:0] tot;
    tot = {1'b0, x} + {1'b0, y} + {8'd0, c};
    it.wide = 1'b0; it.expSum = {8'd0, tot[7:0]}; it.expCout = tot[8];
    it.expOvf = (x[7] == y[7]) && (tot[7] != x[7]);
    it.tag = tag;
    return it;
  endfunction

  // Driver: applies inputs at the rising edge, queues the expectations.
  task automatic drive16(input logic [15:0] x, input logic [15:0] y,
                         input logic c, input string tag);
    @(posedge clk);
    a16 = x; b16 = y; cin16 = c;
    scoreQ.push_back(model16(x, y, c, tag));
  endtask

  task automatic drive8(input logic [7:0] x, input logic [7:0] y,
                        input logic c, input string tag);
    @(posedge clk);
    a8 = x; b8 = y; cin8 = c;
    scoreQ.push_back(model8(x, y, c, tag));
  endtask

  // Monitor: compares at the falling edge, away from input changes.
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      exp_item_t it;
      logic [15:0] gotSum;
      logic gotCout, gotOvf;
      it = scoreQ.pop_front();
      gotSum  = it.wide ? sum16 : {8'd0, sum8};
      gotCout = it.wide ? cout16 : cout8;
      gotOvf  = it.wide ? ovf16 : ovf8;
      applied++;
      if (gotSum !== it.expSum || gotCout !== it.expCout || gotOvf !== it.expOvf) begin
        miscompares++;
        $display("FAIL %s: got sum=%h cout=%b ovf=%b, expected sum=%h cout=%b ovf=%b",
                 it.tag, gotSum, gotCout, gotOvf, it.expSum, it.expCout, it.expOvf);
      end
    end
  end

  initial begin
    a16 = '0; b16 = '0; cin16 = 1'b0;
    a8 = '0; b8 = '0; cin8 = 1'b0;

    // R1 generate at bit 0
    drive16(16'h0001, 16'h0001, 1'b0, "R1");
    drive16(16'h00FF, 16'h00FF, 1'b0, "R1");
    // R2 carry-in ripples through a propagate run
    drive16(16'h7FFF, 16'h0000, 1'b1, "R2");
    drive16(16'h5555, 16'hAAAA, 1'b1, "R2");
    // R3 kill positions stop the chain
    drive16(16'hFF00, 16'h00FF, 1'b0, "R3");
    drive16(16'h0F0F, 16'h0000, 1'b1, "R3");
    // R6 negation as complement plus carry-in
    drive16(~16'h0004, 16'h0000, 1'b1, "R6");
    drive16(~16'h0000, 16'h0000, 1'b1, "R6");
    drive16(~16'h8000, 16'h0000, 1'b1, "R6");
    // R7 same-sign overflow, with and without carry out
    drive16(16'h7FFF, 16'h0001, 1'b0, "R7");
    drive16(16'h8000, 16'h8000, 1'b0, "R7");
    drive16(16'h4000, 16'h4000, 1'b0, "R7");
    // R8 opposite signs: carry out, no overflow
    drive16(16'hFFFF, 16'h0001, 1'b0, "R8");
    drive16(16'h8000, 16'h7FFF, 1'b1, "R8");

    // R4 R5 R7: exhaustive 8-bit operands, both carry-in values
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        drive8(8'(x), 8'(y), (x + y) % 2 == 1 ? 1'b1 : 1'b0, "R4_R5_R7_exh8");
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        drive8(8'(x), 8'(y), (x + y) % 2 == 1 ? 1'b0 : 1'b1, "R4_R5_R7_exh8");

    // R4 R5: random 16-bit vectors
    for (int k = 0; k < 20000; k++)
      drive16(16'($urandom), 16'($urandom), 1'($urandom), "R4_R5_rand16");

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule